// File: doc/BRIEF.md
# Snoopy MESI Cache Line Controller

This block holds the coherence state of one line in a private cache attached to a shared snooping bus. The processor side presents read or write requests and waits on a ready flag. The bus side has three parts:

- a request/grant handshake for the controller's own transactions;
- a completion strobe for those transactions;
- an observation port carrying the transactions of other caches.

On a read miss the controller samples a wired-OR shared line. If another cache holds a copy, the line is installed as shared. Otherwise it is installed as exclusive-clean, so a later write needs no bus transaction. When it snoops a request for a line it holds dirty, it raises a flush strobe to supply the data. It also drives its own contribution to the shared line.

Only one bus operation is in flight at a time, and every controller sees it. A snooped transaction is applied in the cycle it appears, ahead of any processor request waiting on this line. The pending request is then judged again against the updated state.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line state output is Invalid. The state encoding is Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. With no request present, cpu_ready is low.
- R2: A processor read in Invalid issues a read transaction, with bus command code 2'b01. At bus_done the line becomes Shared if shared_in is high in that cycle, and Exclusive otherwise.
- R3: A processor write in Invalid or Shared issues a read-for-ownership transaction, with bus command code 2'b10. At bus_done the line becomes Modified.
- R4: A processor write in Exclusive completes in the same cycle, with cpu_ready high and no bus request, and the line becomes Modified.
- R5: Processor reads in Shared, Exclusive or Modified, and writes in Modified, complete in the same cycle with no bus request. They leave the state unchanged.
- R6: A snooped read (snp_cmd 2'b01) has these effects:
  - in Modified it raises flush_out and moves the line to Shared;
  - in Exclusive it moves the line to Shared;
  - in Shared the state is kept;
  - in Exclusive, Shared or Modified, shared_out is raised;
  - in Invalid there is no effect.
- R7: A snooped read-for-ownership (snp_cmd 2'b10) moves the line to Invalid. flush_out is raised only if the line was Modified.
- R8: A request that needs the bus holds cpu_ready low until bus_done of its own transaction. bus_req rises the cycle after the request and stays high until bus_gnt. bus_cmd shows the command while requesting and while transferring.
- R9: In a cycle with snp_valid high, the processor request is not served and cpu_ready is low. The snoop updates the state first, and the request is then decided against the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read request, held until ready |
| cpu_wr | input | 1 | Processor write request, held until ready |
| cpu_ready | output | 1 | Request completed this cycle |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_cmd | output | 2 | Own command: 00 none, 01 read, 10 read-for-ownership |
| bus_done | input | 1 | Own transaction completes this cycle |
| shared_in | input | 1 | Wired-OR shared line, sampled at bus_done |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| shared_out | output | 1 | This cache holds a copy of a snooped read |
| flush_out | output | 1 | Supply dirty data for the snooped transaction |
| line_state | output | 2 | Current coherence state of the line |

## Verification
A table walks the line through every state. It applies each processor operation and each snoop in each state, so that hit, miss and silent-upgrade cases are told apart by bus_req and by the resulting state.

The read-miss cases are run with shared_in both high and low, which separates the Shared and Exclusive outcomes. Snoops are applied in Modified and in clean states, which separates a flush from a plain invalidate or downgrade.

Directed cases check the stall while the grant is withheld, and a snoop that collides with a processor write. In the collision the write must wait and then take the bus, because the snoop has removed the line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } line_st_t;

   typedef enum logic [1:0] {
      CMD_NONE = 2'b00,
      CMD_RD   = 2'b01,
      CMD_RDX  = 2'b10
   } bus_cmd_t;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'b00,
      SEQ_REQ  = 2'b01,
      SEQ_XFER = 2'b10
   } seq_st_t;
endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
(
   input  line_st_t cur_st,
   input  logic     snp_valid,
   input  bus_cmd_t snp_cmd,
   output line_st_t snp_next,
   output logic     snp_flush,
   output logic     snp_shared
);
   always_comb begin
      snp_next   = cur_st;
      snp_flush  = 1'b0;
      snp_shared = 1'b0;
      if (snp_valid) begin
         unique case (snp_cmd)
            CMD_RD: begin
               if (cur_st != ST_I) begin
                  snp_shared = 1'b1;
                  snp_next   = ST_S;
               end
               snp_flush = (cur_st == ST_M);
            end
            CMD_RDX: begin
               snp_next  = ST_I;
               snp_flush = (cur_st == ST_M);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mesi_cpu_decode.sv
module mesi_cpu_decode
   import mesi_pkg::*;
(
   input  line_st_t cur_st,
   input  logic     cpu_rd,
   input  logic     cpu_wr,
   output logic     hit,
   output line_st_t hit_next,
   output logic     need_bus,
   output bus_cmd_t need_cmd
);
   logic rd_hit, wr_hit;

   always_comb begin
      rd_hit   = cpu_rd && !cpu_wr && (cur_st != ST_I);
      wr_hit   = cpu_wr && ((cur_st == ST_E) || (cur_st == ST_M));
      hit      = rd_hit || wr_hit;
      hit_next = wr_hit ? ST_M : cur_st;
      need_bus = (cpu_rd || cpu_wr) && !hit;
      need_cmd = cpu_wr ? CMD_RDX : CMD_RD;
   end
endmodule

// File: rtl/mesi_bus_seq.sv
module mesi_bus_seq
   import mesi_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     need_bus,
   input  bus_cmd_t need_cmd,
   input  logic     snp_valid,
   input  logic     bus_gnt,
   input  logic     bus_done,
   output logic     bus_req,
   output bus_cmd_t bus_cmd,
   output logic     seq_idle,
   output logic     xfer_done,
   output bus_cmd_t xfer_cmd
);
   seq_st_t  st_q;
   bus_cmd_t cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         cmd_q <= CMD_NONE;
      end else begin
         unique case (st_q)
            SEQ_IDLE: if (need_bus && !snp_valid) st_q <= SEQ_REQ;
            SEQ_REQ: begin
               if (!need_bus) st_q <= SEQ_IDLE;
               else if (bus_gnt) begin
                  st_q  <= SEQ_XFER;
                  cmd_q <= need_cmd;
               end
            end
            SEQ_XFER: if (bus_done) st_q <= SEQ_IDLE;
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_req   = (st_q == SEQ_REQ);
      seq_idle  = (st_q == SEQ_IDLE);
      xfer_done = (st_q == SEQ_XFER) && bus_done;
      xfer_cmd  = cmd_q;
      bus_cmd   = (st_q == SEQ_REQ)  ? need_cmd :
                  (st_q == SEQ_XFER) ? cmd_q    : CMD_NONE;
   end

   // R8: an ungranted request is kept up while the processor still waits
   assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && need_bus) |=> bus_req)
      else $error("bus request dropped before grant");

   // R8: a grant turns into a transfer carrying a real command
   assert_grant_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && need_bus) |=> (bus_cmd != CMD_NONE) && !bus_req)
      else $error("grant did not start a transfer");
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int STATE_W = 2,
   parameter int CMD_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_rd,
   input  logic               cpu_wr,
   output logic               cpu_ready,
   output logic               bus_req,
   input  logic               bus_gnt,
   output logic [CMD_W-1:0]   bus_cmd,
   input  logic               bus_done,
   input  logic               shared_in,
   input  logic               snp_valid,
   input  logic [CMD_W-1:0]   snp_cmd,
   output logic               shared_out,
   output logic               flush_out,
   output logic [STATE_W-1:0] line_state
);
   generate
      if (STATE_W != 2) begin : g_bad_state_w
         $error("STATE_W must be 2 for a four-state line");
      end
      if (CMD_W != 2) begin : g_bad_cmd_w
         $error("CMD_W must be 2 for the three bus commands");
      end
   endgenerate

   line_st_t st_q, snp_next, hit_next, fill_next;
   bus_cmd_t need_cmd, seq_cmd, xfer_cmd;
   logic     hit, need_bus, seq_idle, xfer_done;

   mesi_snoop_resp i_snoop (
      .cur_st    (st_q),
      .snp_valid (snp_valid),
      .snp_cmd   (bus_cmd_t'(snp_cmd)),
      .snp_next  (snp_next),
      .snp_flush (flush_out),
      .snp_shared(shared_out)
   );

   mesi_cpu_decode i_decode (
      .cur_st  (st_q),
      .cpu_rd  (cpu_rd),
      .cpu_wr  (cpu_wr),
      .hit     (hit),
      .hit_next(hit_next),
      .need_bus(need_bus),
      .need_cmd(need_cmd)
   );

   mesi_bus_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .need_bus (need_bus),
      .need_cmd (need_cmd),
      .snp_valid(snp_valid),
      .bus_gnt  (bus_gnt),
      .bus_done (bus_done),
      .bus_req  (bus_req),
      .bus_cmd  (seq_cmd),
      .seq_idle (seq_idle),
      .xfer_done(xfer_done),
      .xfer_cmd (xfer_cmd)
   );

   always_comb begin
      fill_next  = (xfer_cmd == CMD_RDX) ? ST_M : (shared_in ? ST_S : ST_E);
      cpu_ready  = xfer_done || (seq_idle && hit && !snp_valid);
      bus_cmd    = seq_cmd;
      line_state = st_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        st_q <= ST_I;
      else if (snp_valid)                st_q <= snp_next;
      else if (xfer_done)                st_q <= fill_next;
      else if (seq_idle && hit)          st_q <= hit_next;
   end

   // R3/R4: a completed write always leaves the line dirty
   assert_write_ends_modified_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_wr) |=> (st_q == ST_M))
      else $error("completed write did not leave line modified");

   // R2: a completed read leaves a valid copy
   assert_read_leaves_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_rd && !cpu_wr) |=> (st_q != ST_I))
      else $error("completed read left line invalid");

   // R6/R7: after supplying dirty data the line is no longer dirty
   assert_flush_cleans_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_out |=> (st_q != ST_M))
      else $error("line still modified after flush");

   // R4: an exclusive line is written without a bus request
   assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_E && cpu_wr && !snp_valid) |=> !bus_req)
      else $error("exclusive write requested the bus");

   // R9: a snooped cycle never completes a processor request
   assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && seq_idle) |-> !cpu_ready)
      else $error("processor served during a snoop");
endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_rd = 0, cpu_wr = 0, bus_gnt = 0, bus_done = 0, shared_in = 0, snp_valid = 0;
   logic [1:0] snp_cmd = 2'b00;
   logic cpu_ready, bus_req, shared_out, flush_out;
   logic [1:0] bus_cmd, line_state;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   mesi_line_ctrl i_mesi_line_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_ready(cpu_ready),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_done(bus_done),
      .shared_in(shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
      .shared_out(shared_out), .flush_out(flush_out), .line_state(line_state)
   );

   // op[8:7] (0 rd,1 wr,2 snoop rd,3 snoop rdx), shared_in[6], exp state[5:4],
   // exp bus cmd[3:2], exp flush[1], exp shared_out[0]
   localparam int NV = 18;
   localparam logic [8:0] VEC [NV] = '{
      {2'd0, 1'b0, 2'b10, 2'd1, 1'b0, 1'b0},  // R2 miss, unshared -> E
      {2'd1, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0},  // R4 E write silent
      {2'd2, 1'b0, 2'b01, 2'd0, 1'b1, 1'b1},  // R6 M snoop rd flush
      {2'd1, 1'b0, 2'b11, 2'd2, 1'b0, 1'b0},  // R3 S write
      {2'd3, 1'b0, 2'b00, 2'd0, 1'b1, 1'b0},  // R7 M snoop rdx flush
      {2'd0, 1'b1, 2'b01, 2'd1, 1'b0, 1'b0},  // R2 miss, shared -> S
      {2'd0, 1'b0, 2'b01, 2'd0, 1'b0, 1'b0},  // R5 S read hit
      {2'd2, 1'b0, 2'b01, 2'd0, 1'b0, 1'b1},  // R6 S snoop rd
      {2'd3, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0},  // R7 S snoop rdx
      {2'd1, 1'b0, 2'b11, 2'd2, 1'b0, 1'b0},  // R3 I write
      {2'd0, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0},  // R5 M read hit
      {2'd1, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0},  // R5 M write hit
      {2'd3, 1'b0, 2'b00, 2'd0, 1'b1, 1'b0},  // R7 M snoop rdx
      {2'd0, 1'b0, 2'b10, 2'd1, 1'b0, 1'b0},  // R2 -> E
      {2'd2, 1'b0, 2'b01, 2'd0, 1'b0, 1'b1},  // R6 E snoop rd
      {2'd3, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0},  // R7 S snoop rdx
      {2'd2, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0},  // R6 I snoop rd ignored
      {2'd0, 1'b0, 2'b10, 2'd1, 1'b0, 1'b0}   // R2 -> E
   };

   task automatic check(input logic [7:0] got, input logic [7:0] exp, input string what);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", what, got, exp);
      end
   endtask

   task automatic bus_op(input logic [1:0] exp_cmd, input logic sh, input string tag);
      @(posedge clk); @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         check({7'd0, bus_req}, 8'd1, {tag, " R8 bus_req"});
         check({6'd0, bus_cmd}, {6'd0, exp_cmd}, {tag, " R8 cmd requesting"});
         check({7'd0, cpu_ready}, 8'd0, {tag, " R8 stall"});
         @(negedge clk);
      end
      bus_gnt = 1;
      @(negedge clk);
      bus_gnt = 0;
      check({6'd0, bus_cmd}, {6'd0, exp_cmd}, {tag, " R8 cmd transfer"});
      bus_done = 1; shared_in = sh;
      #2 check({7'd0, cpu_ready}, 8'd1, {tag, " R8 ready at done"});
      @(negedge clk);
      bus_done = 0; shared_in = 0;
   endtask

   task automatic run_vec(input logic [8:0] v, input int idx);
      string tag;
      tag = $sformatf("vec%0d", idx);
      @(negedge clk);
      if (v[8] == 1'b0) begin
         cpu_rd = (v[8:7] == 2'd0); cpu_wr = (v[8:7] == 2'd1);
         #2;
         if (v[3:2] == 2'd0) begin
            check({7'd0, cpu_ready}, 8'd1, {tag, " R5 hit ready"});
            @(negedge clk);
            check({7'd0, bus_req}, 8'd0, {tag, " R4 R5 no bus"});
         end else begin
            check({7'd0, cpu_ready}, 8'd0, {tag, " R8 miss stall"});
            bus_op(v[3:2], v[6], tag);
         end
         cpu_rd = 0; cpu_wr = 0;
      end else begin
         snp_valid = 1; snp_cmd = (v[8:7] == 2'd2) ? 2'b01 : 2'b10;
         #2;
         check({7'd0, flush_out}, {7'd0, v[1]}, {tag, " R6 R7 flush"});
         check({7'd0, shared_out}, {7'd0, v[0]}, {tag, " R6 shared_out"});
         @(negedge clk);
         snp_valid = 0; snp_cmd = 0;
      end
      #1 check({6'd0, line_state}, {6'd0, v[5:4]}, {tag, " R2 R3 R6 R7 state"});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({6'd0, line_state}, 8'd0, "R1 reset state");
      rst_n = 1;
      @(negedge clk);
      check({6'd0, line_state}, 8'd0, "R1 state after reset");
      check({7'd0, cpu_ready}, 8'd0, "R1 idle ready low");
      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);
      // R9: snoop rdx collides with a write in Exclusive
      @(negedge clk);
      cpu_wr = 1; snp_valid = 1; snp_cmd = 2'b10;
      #2 check({7'd0, cpu_ready}, 8'd0, "R9 no service during snoop");
      check({7'd0, flush_out}, 8'd0, "R9 R7 clean no flush");
      @(negedge clk);
      snp_valid = 0; snp_cmd = 0;
      #1 check({6'd0, line_state}, 8'd0, "R9 snoop applied first");
      check({7'd0, cpu_ready}, 8'd0, "R9 write now a miss");
      bus_op(2'd2, 1'b0, "R9 rerun");
      cpu_wr = 0;
      #1 check({6'd0, line_state}, 8'd3, "R9 R3 write ends modified");
      // R1: reset from Modified
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      check({6'd0, line_state}, 8'd0, "R1 reset clears modified");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule